// File: doc/BRIEF.md
# Nibble-Access Reloadable Timer Counter

This block is an 8-bit up-counting timer and event counter that sits on a 4-bit processor bus. It counts on a one-cycle enable pulse taken from a free-running 11-bit prescaler, or from rising edges on an external event pin. Software reaches the 8-bit load value and the 8-bit count through two nibble addresses. A mode nibble selects the clock source and chooses between auto-reload and free wrap. A control nibble holds the overflow request flag and its mask, and the mask gates the flag onto `irq_o`.

Both 8-bit transfers follow a fixed nibble order. For a load, software writes the low nibble first. Writing the high nibble then commits the whole load value into the counter. For a read, software reads the high nibble first, which freezes the low nibble in a holding latch, and then reads the low nibble. A two-state read sequencer tracks this. In `RD_LIVE`, a low-nibble read returns the live count. A high-nibble read takes the transition `live_to_frozen` into `RD_FROZEN` and captures the low nibble. In `RD_FROZEN`, a further high-nibble read takes `frozen_recapture`, which stays in `RD_FROZEN` and captures again. A low-nibble read takes `frozen_to_live`, which returns the latched value and goes back to `RD_LIVE`.

Top module: `nib_timer`

## Requirements
- R1: After reset the count, the load value and the mode nibble are 0x0, the request flag is 0, the mask is 1, `irq_o` is 0 and the read sequencer is in `RD_LIVE`.
- R2: Mode bits 2:0 pick the count enable from an 11-bit divider that runs freely from reset. Codes 0 to 6 divide by 2048, 512, 128, 32, 8, 4 and 2. A code that divides by 2^k gives one enable in each cycle in which the low k divider bits are all ones.
- R3: Mode code 7 counts external events. `evt_i` passes through a two-flop synchronizer, and each rising edge after it gives exactly one count enable.
- R4: Each count enable adds 1 to the count, and with no enable the count holds. With mode bit 3 at 0, an enable at 0xFF wraps the count to 0x00.
- R5: With mode bit 3 at 1, an enable at 0xFF reloads the count from the 8-bit load value.
- R6: A write to address 0 stores the low load nibble. A write to address 1 stores the high load nibble and, in the same edge, loads the full value into the count. This write takes priority over a count enable in that cycle, and that enable then raises no overflow.
- R7: A read of address 1 returns count bits 7:4 and latches count bits 3:0. A read of address 0 returns the latch while the sequencer is in `RD_FROZEN` and the live bits 3:0 while it is in `RD_LIVE`.
- R8: An overflow sets the flag (control bit 0). Writing address 3 with bit 0 at 0 clears the flag, and writing it with bit 0 at 1 leaves the flag unchanged. If a clear and an overflow fall in the same cycle, the flag ends up set.
- R9: `irq_o` is 1 exactly when the flag is 1 and the mask (control bit 1) is 0. A write to address 3 sets the mask from bit 1.
- R10: Address 2 reads and writes the mode nibble, and address 3 reads as {0, 0, mask, flag}. `rdata_o` is 0 whenever `rd_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per access |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| addr_i | input | 2 | Register select: 0 low nibble, 1 high nibble, 2 mode, 3 control |
| wdata_i | input | 4 | Write nibble |
| rdata_o | output | 4 | Read nibble, combinational from the state and the address |
| evt_i | input | 1 | External event input, asynchronous |
| irq_o | output | 1 | Masked interrupt request |

## Verification
Directed passes step through each prescaler code, including the slowest divide ratio. They tell apart the exact tick phase of each code and the way each code maps to a ratio. Loads of 0xFE and 0xFC, run with auto-reload both off and on, separate wrap from reload and test the flag set, clear and mask paths. A slowly toggled `evt_i` in code 7 shows that each edge gives one count and that the synchronizer delays it by the stated number of cycles. A long random phase mixes reads, writes, mode changes and event toggles. It hits the collisions that directed tests reach only by luck: a load against a tick, a clear against an overflow, and low reads in both sequencer states.

// File: rtl/nib_timer_pkg.sv
package nib_timer_pkg;
    localparam int CNT_W   = 8;
    localparam int NIB_W   = 4;
    localparam int DIV_W   = 11;
    localparam int SEL_W   = 3;
    localparam int N_SEL   = 1 << SEL_W;
    localparam int ADDR_W  = 2;

    typedef enum logic {
        RD_LIVE   = 1'b0,
        RD_FROZEN = 1'b1
    } rd_state_t;

    typedef enum logic [ADDR_W-1:0] {
        A_LO   = 2'd0,
        A_HI   = 2'd1,
        A_MODE = 2'd2,
        A_CTRL = 2'd3
    } reg_addr_t;

    // number of low divider bits that must be all ones for a given code
    function automatic int ratio_bits(input int code);
        case (code)
            0:       return 11;
            1:       return 9;
            2:       return 7;
            3:       return 5;
            4:       return 3;
            5:       return 2;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/nt_evt_sync.sv
module nt_evt_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    output logic evt_pulse
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= evt_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign evt_pulse = sync_q & ~prev_q;
endmodule

// File: rtl/nt_prescaler.sv
module nt_prescaler #(
    parameter int DIV_W = nib_timer_pkg::DIV_W,
    parameter int SEL_W = nib_timer_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             ext_pulse,
    output logic             tick
);
    localparam int N_SEL = 1 << SEL_W;

    logic [DIV_W-1:0] div_q;
    logic [N_SEL-1:0] taps;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    for (genvar s = 0; s < N_SEL - 1; s++) begin : g_tap
        localparam int K = nib_timer_pkg::ratio_bits(s);
        assign taps[s] = &div_q[K-1:0];
    end
    assign taps[N_SEL-1] = ext_pulse;

    assign tick = taps[sel];
endmodule

// File: rtl/nt_count_core.sv
module nt_count_core #(
    parameter int CNT_W = nib_timer_pkg::CNT_W,
    parameter int NIB_W = nib_timer_pkg::NIB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload_en,
    input  logic             lo_we,
    input  logic             hi_we,
    input  logic [NIB_W-1:0] wnib,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] load_val,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] count_q, load_q;
    logic             at_top;

    assign at_top = (count_q == TOP);
    assign ovf    = tick & at_top & ~hi_we;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (lo_we) begin
            load_q[NIB_W-1:0] <= wnib;
        end else if (hi_we) begin
            load_q[CNT_W-1:NIB_W] <= wnib;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (hi_we) begin
            count_q <= {wnib, load_q[NIB_W-1:0]};
        end else if (tick) begin
            if (at_top) count_q <= reload_en ? load_q : '0;
            else        count_q <= count_q + 1'b1;
        end
    end

    assign count    = count_q;
    assign load_val = load_q;
endmodule

// File: rtl/nib_timer.sv
module nib_timer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    input  logic [1:0] addr_i,
    input  logic [3:0] wdata_i,
    output logic [3:0] rdata_o,
    input  logic       evt_i,
    output logic       irq_o
);
    import nib_timer_pkg::*;

    localparam int RELOAD_BIT = NIB_W - 1;

    logic [NIB_W-1:0] mode_q;
    logic             flag_q, mask_q;
    logic [NIB_W-1:0] hold_q;
    rd_state_t        state_q, state_d;

    logic             evt_pulse, tick, ovf;
    logic [CNT_W-1:0] count, load_val;
    logic             lo_we, hi_we, mode_we, ctrl_we, hi_rd, lo_rd;

    assign lo_we   = wr_en_i & (addr_i == A_LO);
    assign hi_we   = wr_en_i & (addr_i == A_HI);
    assign mode_we = wr_en_i & (addr_i == A_MODE);
    assign ctrl_we = wr_en_i & (addr_i == A_CTRL);
    assign hi_rd   = rd_en_i & (addr_i == A_HI);
    assign lo_rd   = rd_en_i & (addr_i == A_LO);

    nt_evt_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_in    (evt_i),
        .evt_pulse (evt_pulse)
    );

    nt_prescaler #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (mode_q[SEL_W-1:0]),
        .ext_pulse (evt_pulse),
        .tick      (tick)
    );

    nt_count_core #(.CNT_W(CNT_W), .NIB_W(NIB_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reload_en (mode_q[RELOAD_BIT]),
        .lo_we     (lo_we),
        .hi_we     (hi_we),
        .wnib      (wdata_i),
        .count     (count),
        .load_val  (load_val),
        .ovf       (ovf)
    );

    // mode and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            flag_q <= 1'b0;
            mask_q <= 1'b1;
        end else begin
            if (mode_we) mode_q <= wdata_i;
            if (ctrl_we) mask_q <= wdata_i[1];
            if (ovf)                        flag_q <= 1'b1;
            else if (ctrl_we && !wdata_i[0]) flag_q <= 1'b0;
        end
    end

    // read sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_LIVE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (hi_rd) hold_q <= count[NIB_W-1:0];
        end
    end

    // read sequencer: transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_LIVE: begin
                if (hi_rd) state_d = RD_FROZEN;          // live_to_frozen
            end
            RD_FROZEN: begin
                if (hi_rd)      state_d = RD_FROZEN;     // frozen_recapture
                else if (lo_rd) state_d = RD_LIVE;       // frozen_to_live
            end
            default: state_d = RD_LIVE;
        endcase
    end

    // outputs
    always_comb begin
        rdata_o = '0;
        if (rd_en_i) begin
            unique case (addr_i)
                A_LO:   rdata_o = (state_q == RD_FROZEN) ? hold_q : count[NIB_W-1:0];
                A_HI:   rdata_o = count[CNT_W-1:NIB_W];
                A_MODE: rdata_o = mode_q;
                A_CTRL: rdata_o = {2'b00, mask_q, flag_q};
                default: rdata_o = '0;
            endcase
        end
    end

    assign irq_o = flag_q & ~mask_q;
endmodule

// File: rtl/nib_timer_chk.sv
module nib_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en_i,
    input logic       rd_en_i,
    input logic [1:0] addr_i,
    input logic [3:0] wdata_i,
    input logic [7:0] count,
    input logic [7:0] load_val,
    input logic       tick,
    input logic       ovf,
    input logic       flag_q,
    input logic       mask_q,
    input logic       irq_o,
    input logic [3:0] hold_q,
    input logic [3:0] mode_q
);
    logic wr_hi;
    assign wr_hi = wr_en_i && (addr_i == 2'd1);

    a_r6_hi_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> count == {$past(wdata_i), $past(load_val[3:0])});

    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == 8'hFF && !mode_q[3] && !wr_hi) |=> count == 8'h00);

    a_r4_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_hi) |=> $stable(count));

    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count == 8'hFF && mode_q[3] && !wr_hi) |=> count == $past(load_val));

    a_r8_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag_q);

    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q |-> !irq_o);

    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == 2'd1) |=> hold_q == $past(count[3:0]));
endmodule

bind nib_timer nib_timer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .count    (count),
    .load_val (load_val),
    .tick     (tick),
    .ovf      (ovf),
    .flag_q   (flag_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o),
    .hold_q   (hold_q),
    .mode_q   (mode_q)
);

// File: tb/nib_timer_tb_top.sv
module nib_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, evt = 1'b0;
    logic [1:0] addr = '0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;
    logic       irq;

    int n_cmp = 0, n_bad = 0, cyc = 0;

    always #5 clk = ~clk;

    nib_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .evt_i(evt), .irq_o(irq)
    );

    // reference state
    logic [10:0] m_div;
    logic [7:0]  m_cnt, m_load;
    logic [3:0]  m_mode, m_hold;
    logic        m_flag, m_mask, m_frozen, m_s1, m_s2, m_s3;

    function automatic int bits_for(input logic [2:0] code);
        case (code)
            3'd0: return 11;
            3'd1: return 9;
            3'd2: return 7;
            3'd3: return 5;
            3'd4: return 3;
            3'd5: return 2;
            default: return 1;
        endcase
    endfunction

    function automatic logic [3:0] exp_rdata();
        if (!rd_en) return 4'h0;
        case (addr)
            2'd0: return m_frozen ? m_hold : m_cnt[3:0];
            2'd1: return m_cnt[7:4];
            2'd2: return m_mode;
            default: return {2'b00, m_mask, m_flag};
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = '0; m_cnt = '0; m_load = '0; m_mode = '0; m_hold = '0;
            m_flag = 0; m_mask = 1; m_frozen = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            logic edge_p, tk, whi, ovf;
            int   k;
            edge_p = m_s2 & ~m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt;
            k = bits_for(m_mode[2:0]);
            if (m_mode[2:0] == 3'd7) tk = edge_p;
            else tk = ((m_div & ((11'd1 << k) - 11'd1)) == ((11'd1 << k) - 11'd1));
            m_div = m_div + 1'b1;
            whi = wr_en && addr == 2'd1;
            ovf = tk && m_cnt == 8'hFF && !whi;
            if (rd_en && addr == 2'd1) begin m_hold = m_cnt[3:0]; m_frozen = 1; end
            else if (rd_en && addr == 2'd0) m_frozen = 0;
            if (whi) begin
                m_load[7:4] = wdata;
                m_cnt = m_load;
            end else if (tk) begin
                if (m_cnt == 8'hFF) m_cnt = m_mode[3] ? m_load : 8'h00;
                else m_cnt = m_cnt + 1'b1;
            end
            if (wr_en && addr == 2'd0) m_load[3:0] = wdata;
            if (wr_en && addr == 2'd2) m_mode = wdata;
            if (wr_en && addr == 2'd3) m_mask = wdata[1];
            if (ovf) m_flag = 1;
            else if (wr_en && addr == 2'd3 && !wdata[0]) m_flag = 0;
        end
    end

    task automatic check(input string tag);
        logic [3:0] e;
        e = exp_rdata();
        n_cmp++;
        if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, addr, rdata, e);
        end
        n_cmp++;
        if (irq !== (m_flag & ~m_mask)) begin
            n_bad++;
            $display("FAIL R9 irq actual=%b expected=%b", irq, m_flag & ~m_mask);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic [1:0] a,
                        input logic [3:0] d, input string tag);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        #1 check(tag);
        @(posedge clk);
    endtask

    task automatic idle_read(input int n, input string tag);
        for (int i = 0; i < n; i++) step(0, 1, 2'(i % 2 == 0 ? 1 : 0), 4'h0, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) step(0, 1, 2'(a), 4'h0, "R1");
        step(0, 0, 2'd0, 4'h0, "R10");
        // R2: each divider code, observed with alternating high/low reads
        for (int c = 6; c >= 1; c--) begin
            step(1, 0, 2'd2, 4'(c), "R2");
            idle_read(150, "R2");
        end
        step(1, 0, 2'd2, 4'd0, "R2");
        idle_read(2200, "R2");
        // R6/R4: load 0xFE, wrap with reload off, unmask
        step(1, 0, 2'd3, 4'b0000, "R8");
        step(1, 0, 2'd0, 4'hE, "R6");
        step(1, 0, 2'd1, 4'hF, "R6");
        step(1, 0, 2'd2, 4'd6, "R4");
        idle_read(12, "R4");
        step(0, 1, 2'd3, 4'h0, "R8");
        step(1, 0, 2'd3, 4'b0001, "R8");  // writing 1 leaves flag
        step(0, 1, 2'd3, 4'h0, "R8");
        step(1, 0, 2'd3, 4'b0000, "R8");  // clear
        step(0, 1, 2'd3, 4'h0, "R8");
        // R5: reload from 0xFC
        step(1, 0, 2'd0, 4'hC, "R5");
        step(1, 0, 2'd1, 4'hF, "R5");
        step(1, 0, 2'd2, 4'hE, "R5");
        idle_read(40, "R5");
        step(0, 1, 2'd3, 4'h0, "R9");
        step(1, 0, 2'd3, 4'b0010, "R9");
        step(0, 1, 2'd3, 4'h0, "R9");
        // R7: low read without a preceding high read, then frozen pair
        step(0, 1, 2'd0, 4'h0, "R7");
        step(0, 1, 2'd1, 4'h0, "R7");
        step(0, 0, 2'd0, 4'h0, "R7");
        step(0, 0, 2'd0, 4'h0, "R7");
        step(0, 1, 2'd0, 4'h0, "R7");
        step(0, 1, 2'd0, 4'h0, "R7");
        // R3: external events
        step(1, 0, 2'd2, 4'h7, "R3");
        for (int e = 0; e < 20; e++) begin
            @(negedge clk) evt = ~evt;
            idle_read(4, "R3");
        end
        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] a;
            logic [3:0] d;
            int op;
            op = $urandom_range(0, 9);
            a = 2'($urandom_range(0, 3));
            d = 4'($urandom_range(0, 15));
            if (a == 2'd2 && op < 3) d[2:0] = 3'($urandom_range(4, 7));
            if ($urandom_range(0, 3) == 0) evt = ~evt;
            if (op < 3)      step(1, 0, a, d, "R6");
            else if (op < 9) step(0, 1, a, d, a == 2'd0 ? "R7" : (a == 2'd1 ? "R4" : (a == 2'd2 ? "R10" : "R8")));
            else             step(0, 0, a, d, "R10");
        end
        finish_run();
    end
endmodule